// File: doc/BRIEF.md
# Link Start-Up Sequencer

This block walks a serial fronthaul link from power-on standby to normal traffic. After reset it enters layer-1 synchronization. It then moves through the negotiation phases in a fixed order: line bit rate, protocol version, control-and-management channel, and the interface / vendor-specific phase. Each phase ends when external negotiation logic raises a single-bit "complete" flag. The block moves exactly one phase per clock, even when several completion flags are already high.

A loss of synchronization or an expiry of the external layer-1 timer drops the machine back to synchronization. This applies while the link is in any negotiation phase or in operation, and it also clears the recorded completion flags. During control-and-management setup, a request for passive operation parks the link in a passive state. Only an explicit restart request takes it out of that state, back to standby.

The current state is driven on a 3-bit port with Gray-like codes. A combinational register read port returns the recorded completion flags and the state code at one fixed address.

Top module: `link_startup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state code becomes 000 (Standby) and all four recorded flags become 0.
- R2: From Standby (000) the state code becomes 001 (L1 Sync) on the next clock, whatever the other inputs are.
- R3: In L1 Sync the machine moves to Protocol Setup (011) only on a clock where `sync_ok` and `rate_done` are both high. Otherwise it stays at 001.
- R4: The machine advances one phase per clock: 011 to 010 (C&M Setup) on `proto_done`, 010 to 110 (Interface Negotiation) on `cm_done`, and 110 to 111 (Operation) on `vss_done`. Operation holds while no fault is present.
- R5: In states 011, 010, 110 or 111, a clock with `l1_expire` high or `sync_ok` low returns the state to 001 and clears all four recorded flags. This takes priority over every other transition.
- R6: `l1_expire` has no effect on the state or the flags while it is low. It also has no effect while the state is 000, 001 or 101.
- R7: In C&M Setup, with no fault present, `passive_req` moves the state to Passive Link (101) ahead of `cm_done`. In any other state `passive_req` is ignored.
- R8: Passive Link (101) holds until a clock with `restart_req` high, which moves it to Standby (000). `restart_req` is ignored in all other states.
- R9: Recorded flag bit 0 = rate, bit 1 = protocol, bit 2 = C&M, bit 3 = vendor-specific. On each clock outside Standby with no fault, a bit is set when its completion input is high. Once set it stays set until a fault or a clock in Standby clears it.
- R10: A read at address 0x24 returns the flags in bits [3:0], the state code in bits [6:4] and zeros above. Any other address returns zero. The read is combinational, with no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_ok | input | 1 | Layer-1 synchronization achieved |
| rate_done | input | 1 | Line bit rate negotiation complete |
| proto_done | input | 1 | Protocol version negotiation complete |
| cm_done | input | 1 | Control-and-management negotiation complete |
| vss_done | input | 1 | Vendor-specific negotiation complete |
| l1_expire | input | 1 | External layer-1 timer expired |
| passive_req | input | 1 | Request to enter passive link mode |
| restart_req | input | 1 | Request to leave passive link mode |
| rd_addr | input | ADDR_W | Register read address |
| state_code | output | 3 | Current state code |
| rd_data | output | DATA_W | Register read data |

## Verification
A wrong internal state shows on `state_code` on the same clock it is entered, and on `rd_data` bits [6:4] as soon as address 0x24 is presented. A skipped or repeated phase therefore shows as a wrong code one cycle after the triggering flags. A flag latch that fails to clear or to hold shows up on the next read after the fault, Standby clock or completion input that should have changed it. The bench walks the full path several times, injecting faults, passive requests, restarts and stray inputs in states where they must be ignored. It checks both the state port and the read port after every clock.

// File: rtl/lss_pkg.sv
// Shared definitions for the link start-up sequencer.
// Assumes: 3-bit state codes are fixed because software decodes them.
package lss_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY = 3'b000,
        ST_L1SYNC  = 3'b001,
        ST_PROTO   = 3'b011,
        ST_CMSET   = 3'b010,
        ST_IFNEG   = 3'b110,
        ST_OPER    = 3'b111,
        ST_PASSIVE = 3'b101
    } lss_state_e;

    localparam int unsigned LSS_STATE_W = 3;
    localparam int unsigned LSS_FLAGS   = 4;
    localparam int unsigned FLAG_RATE   = 0;
    localparam int unsigned FLAG_PROTO  = 1;
    localparam int unsigned FLAG_CM     = 2;
    localparam int unsigned FLAG_VSS    = 3;

endpackage

// File: rtl/lss_fsm.sv
// Start-up state machine: standby, L1 sync, four negotiation steps, operation
// and a passive branch. Advances at most one phase per clock.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module lss_fsm
    import lss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_ok,
    input  logic       rate_done,
    input  logic       proto_done,
    input  logic       cm_done,
    input  logic       vss_done,
    input  logic       l1_expire,
    input  logic       passive_req,
    input  logic       restart_req,
    output lss_state_e state_q,
    output logic       fault_o
);

    lss_state_e state_d;
    logic       active;

    // Purpose: detect states in which a sync loss or timer expiry is a fault.
    always_comb begin
        active  = (state_q == ST_PROTO) || (state_q == ST_CMSET) ||
                  (state_q == ST_IFNEG) || (state_q == ST_OPER);
        fault_o = active && (l1_expire || !sync_ok);
    end

    // Purpose: compute the next state from the current state and handshakes.
    always_comb begin
        state_d = state_q;
        if (fault_o) begin
            state_d = ST_L1SYNC;
        end else begin
            unique case (state_q)
                ST_STANDBY: state_d = ST_L1SYNC;
                ST_L1SYNC:  if (sync_ok && rate_done) state_d = ST_PROTO;
                ST_PROTO:   if (proto_done) state_d = ST_CMSET;
                ST_CMSET: begin
                    if (passive_req)  state_d = ST_PASSIVE;
                    else if (cm_done) state_d = ST_IFNEG;
                end
                ST_IFNEG:   if (vss_done) state_d = ST_OPER;
                ST_OPER:    state_d = ST_OPER;
                ST_PASSIVE: if (restart_req) state_d = ST_STANDBY;
                default:    state_d = ST_STANDBY;
            endcase
        end
    end

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> state_q == ST_STANDBY);

    assert_standby_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STANDBY |=> state_q == ST_L1SYNC);

    assert_l1_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_L1SYNC && !(sync_ok && rate_done)) |=> state_q == ST_L1SYNC);

    assert_oper_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPER && sync_ok && !l1_expire) |=> state_q == ST_OPER);

    assert_fault_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> state_q == ST_L1SYNC);

    assert_passive_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASSIVE && !restart_req) |=> state_q == ST_PASSIVE);

    assert_passive_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PASSIVE && state_q != ST_CMSET) |=> state_q != ST_PASSIVE);

endmodule

// File: rtl/lss_status_flags.sv
// Sticky record of negotiation-complete inputs, one bit per phase.
// Assumes: clr comes from the state machine (fault or Standby) and wins over set.
module lss_status_flags #(
    parameter int unsigned N = lss_pkg::LSS_FLAGS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set_in,
    output logic [N-1:0] flags_q
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            // Purpose: hold one completion flag until cleared.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) flags_q[i] <= 1'b0;
                else if (set_in[i]) flags_q[i] <= 1'b1;
            end
        end
    endgenerate

    assert_flags_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> flags_q == '0);

    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (flags_q & $past(flags_q)) == $past(flags_q));

endmodule

// File: rtl/lss_read_port.sv
// Combinational register read: flags and state code at one address, zero elsewhere.
// Assumes: DATA_W is at least the payload width of seven bits.
module lss_read_port #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [lss_pkg::LSS_STATE_W-1:0] state,
    input  logic [lss_pkg::LSS_FLAGS-1:0] flags,
    output logic [DATA_W-1:0]             rd_data
);

    localparam int unsigned PAYLOAD_W = lss_pkg::LSS_STATE_W + lss_pkg::LSS_FLAGS;
    localparam int unsigned PAD_W     = DATA_W - PAYLOAD_W;

    logic hit;

    // Purpose: decode the status address and assemble the read word.
    always_comb begin
        hit     = (rd_addr == STATUS_ADDR);
        rd_data = '0;
        if (hit) rd_data = {{PAD_W{1'b0}}, state, flags};
    end

    assert_pad_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:PAYLOAD_W] == '0);

endmodule

// File: rtl/link_startup_seq.sv
// Top of the link start-up sequencer: state machine, flag record, read port.
// Assumes: one link clock, synchronous active-low reset, inputs already synchronized.
module link_startup_seq #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_ok,
    input  logic              rate_done,
    input  logic              proto_done,
    input  logic              cm_done,
    input  logic              vss_done,
    input  logic              l1_expire,
    input  logic              passive_req,
    input  logic              restart_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [2:0]        state_code,
    output logic [DATA_W-1:0] rd_data
);
    import lss_pkg::*;

    lss_state_e           state;
    logic                 fault;
    logic                 flag_clr;
    logic [LSS_FLAGS-1:0] flag_set;
    logic [LSS_FLAGS-1:0] flags;

    lss_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_ok     (sync_ok),
        .rate_done   (rate_done),
        .proto_done  (proto_done),
        .cm_done     (cm_done),
        .vss_done    (vss_done),
        .l1_expire   (l1_expire),
        .passive_req (passive_req),
        .restart_req (restart_req),
        .state_q     (state),
        .fault_o     (fault)
    );

    // Purpose: route completion inputs to flag bits and form the clear.
    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_RATE]  = rate_done;
        flag_set[FLAG_PROTO] = proto_done;
        flag_set[FLAG_CM]    = cm_done;
        flag_set[FLAG_VSS]   = vss_done;
        flag_clr             = fault || (state == ST_STANDBY);
        state_code           = state;
    end

    lss_status_flags #(.N(LSS_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flag_clr),
        .set_in  (flag_set),
        .flags_q (flags)
    );

    lss_read_port #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .state   (state),
        .flags   (flags),
        .rd_data (rd_data)
    );

    assert_reset_flags_R1: assert property (@(posedge clk)
        !rst_n |=> flags == '0);

endmodule

// File: tb/link_startup_seq_test.sv
module link_startup_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_ok = 1'b0, rate_done = 1'b0, proto_done = 1'b0;
    logic        cm_done = 1'b0, vss_done = 1'b0, l1_expire = 1'b0;
    logic        passive_req = 1'b0, restart_req = 1'b0;
    logic [7:0]  rd_addr = 8'h24;
    logic [2:0]  state_code;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    link_startup_seq uut (
        .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .rate_done(rate_done),
        .proto_done(proto_done), .cm_done(cm_done), .vss_done(vss_done),
        .l1_expire(l1_expire), .passive_req(passive_req), .restart_req(restart_req),
        .rd_addr(rd_addr), .state_code(state_code), .rd_data(rd_data)
    );

    // Vector: {req[3:0], stim[7:0], state[2:0], flags[3:0]}
    // stim bits: 7 sync_ok, 6 rate, 5 proto, 4 cm, 3 vss, 2 l1_expire, 1 passive, 0 restart
    localparam int NV = 23;
    localparam logic [18:0] VEC [NV] = '{
        {4'd2,  8'b00000000, 3'b001, 4'b0000}, // R2 standby -> L1 sync
        {4'd3,  8'b10000000, 3'b001, 4'b0000}, // R3 sync alone
        {4'd3,  8'b01000000, 3'b001, 4'b0001}, // R3 rate alone, R9 flag set
        {4'd3,  8'b11000000, 3'b011, 4'b0001}, // R3 both
        {4'd4,  8'b11111000, 3'b010, 4'b1111}, // R4 one step only
        {4'd4,  8'b11111000, 3'b110, 4'b1111}, // R4
        {4'd4,  8'b11111000, 3'b111, 4'b1111}, // R4
        {4'd4,  8'b10000000, 3'b111, 4'b1111}, // R4 operation holds
        {4'd5,  8'b10000100, 3'b001, 4'b0000}, // R5 timer expiry
        {4'd9,  8'b11000000, 3'b011, 4'b0001}, // R9
        {4'd9,  8'b10100000, 3'b010, 4'b0011}, // R9
        {4'd7,  8'b10010010, 3'b101, 4'b0111}, // R7 passive beats cm_done
        {4'd6,  8'b00001100, 3'b101, 4'b1111}, // R6 expiry in passive ignored, R8 hold
        {4'd8,  8'b10000001, 3'b000, 4'b1111}, // R8 restart
        {4'd9,  8'b00000000, 3'b001, 4'b0000}, // R9 cleared in standby
        {4'd3,  8'b11000000, 3'b011, 4'b0001}, // R3
        {4'd5,  8'b00000000, 3'b001, 4'b0000}, // R5 loss of sync
        {4'd3,  8'b11000000, 3'b011, 4'b0001}, // R3
        {4'd7,  8'b10000010, 3'b011, 4'b0001}, // R7 passive ignored outside C&M
        {4'd4,  8'b10100000, 3'b010, 4'b0011}, // R4
        {4'd5,  8'b10010110, 3'b001, 4'b0000}, // R5 fault beats passive
        {4'd3,  8'b11000000, 3'b011, 4'b0001}, // R3
        {4'd8,  8'b10000001, 3'b011, 4'b0001}  // R8 restart ignored outside passive
    };

    task automatic drive(input logic [7:0] s);
        {sync_ok, rate_done, proto_done, cm_done, vss_done,
         l1_expire, passive_req, restart_req} = s;
    endtask

    task automatic check32(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_state(input int req, input logic [2:0] st, input logic [3:0] fl);
        check32(req, {29'b0, state_code}, {29'b0, st});
        rd_addr = 8'h24;
        #1;
        check32(req, rd_data, {25'b0, st, fl});
    endtask

    task automatic step(input logic [7:0] s);
        drive(s);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        drive(8'b11111111);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_state(1, 3'b000, 4'b0000);
        drive(8'b00000000);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][14:7]);
            check_state(int'(VEC[i][18:15]), VEC[i][6:4], VEC[i][3:0]);
        end

        // R10: other addresses read zero
        rd_addr = 8'h20; #1; check32(10, rd_data, 32'h0);
        rd_addr = 8'h25; #1; check32(10, rd_data, 32'h0);
        rd_addr = 8'hFF; #1; check32(10, rd_data, 32'h0);
        rd_addr = 8'h24; #1; check32(10, rd_data, {25'b0, 3'b011, 4'b0001});

        // R1: reset mid-operation with every input high
        step(8'b10100000); // to 010
        rst_n = 1'b0;
        step(8'b11111111);
        check_state(1, 3'b000, 4'b0000);
        rst_n = 1'b1;

        // R2: exit from standby with inputs active
        step(8'b11111111);
        check_state(2, 3'b001, 4'b0000);

        // R6: expiry in L1 sync ignored
        step(8'b10000100);
        check_state(6, 3'b001, 4'b0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule